// File: doc/BRIEF.md
# Keyed-Control Watchdog Timer

This block is a watchdog that counts bus clock cycles and raises a one-cycle expiry pulse when software stops servicing it. Software reaches it through a single 32-bit configuration register on a plain write-strobe and read-data port. The timer cannot be started, stopped or restarted by one stray store. Each of those actions takes a two-write handshake in a 2-bit field that belongs to that action: the first write sets the field to 1 and the second sets it to 2.

The register holds a reload value that gives the timeout in steps of 256 bus cycles. A read-only flag in the top bit shows whether the timer is running. Every write, including each write of a handshake, also stores the reload value it carries. The enable handshake flips the timer between enabled and disabled. The service handshake restarts the countdown, and only has an effect while the timer runs. When the countdown runs out, the block pulses its expiry output for one cycle and then stays idle until it is serviced or enabled again.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the running flag (read bit 31) is 0, `rd_data` reads all zeros and `wdt_expire` is low.
- R2: Writing 1 and then 2 to the enable field (bits 25:24) in two successive writes flips the running flag. Writes with `wr_en` low between the two do not matter.
- R3: Only a value of 1 arms a field's handshake. A write with any other value in that field disarms it, so a 2 that does not directly follow an armed 1 has no effect. This covers 0, 3, a repeated 2, and a 1-0-2 sequence.
- R4: Writing 1 and then 2 to the service field (bits 27:26) while the timer runs restarts the full timeout. The restart uses the reload value carried by the completing write.
- R5: A service handshake completed while the timer is disabled leaves the running flag at 0 and produces no expiry pulse.
- R6: When the timer is enabled with reload value N (bits 23:0 of the completing write), `wdt_expire` rises exactly N*256 clock edges after that write. For N = 0 it rises one edge after that write.
- R7: `wdt_expire` is high for exactly one cycle. After it, no further pulse occurs until a reload, and the running flag stays 1.
- R8: A write to bit 31 is ignored. Reads return 0 in bits 30:24, and bits 23:0 return the reload field of the most recent write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data: running flag, zeros, reload value |
| wdt_expire | output | 1 | One-cycle pulse when the countdown runs out |

## Verification
The enable field is swept over every ordered pair of values from 0 to 3. This separates the single pair that toggles the timer from the fifteen that must not, including pairs where a stray 2 would toggle a design that does not disarm. Reload values from 0 to 3 are timed edge by edge. These runs tell the N*256 law apart from off-by-one and off-by-prescale errors, and they single out the immediate expiry at zero. Further sequences check the following:
- a service restart mid-count, which separates a real reload from a countdown that just continues;
- a service while disabled;
- a broken 1-0-2 handshake;
- a write that sets the read-only and reserved bits.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int REG_W        = 32;
   localparam int RELOAD_MAX_W = 24;
   localparam int EN_LSB       = 24;
   localparam int SVC_LSB      = 26;
   localparam int RUN_BIT      = 31;
   typedef logic [1:0] key_t;
   localparam key_t KEY_ARM = 2'd1;
   localparam key_t KEY_GO  = 2'd2;
endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
   import wdt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  key_t field,
   output logic fire
);
   logic armed;

   always_ff @(posedge clk) begin
      if (!rst_n)
         armed <= 1'b0;
      else if (wr_en)
         armed <= (field == KEY_ARM);
   end

   assign fire = wr_en && armed && (field == KEY_GO);

   // R3
   arm_on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && field == KEY_ARM) |=> armed);
   // R3
   disarm_on_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && field != KEY_ARM) |=> !armed);
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
   parameter int RELOAD_W = 24,
   parameter int PRE_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                active,
   input  logic                load,
   input  logic [RELOAD_W-1:0] load_val,
   output logic                expire
);
   logic [RELOAD_W-1:0] cnt;
   logic                halted;
   logic                tick;
   logic                step;

   assign step = active && !halted;

   generate
      if (PRE_W < 0 || PRE_W > 16) begin : g_bad_pre
         $error("wdt_countdown: PRE_W out of range");
      end
      if (PRE_W > 0) begin : g_pre
         logic [PRE_W-1:0] pre;
         always_ff @(posedge clk) begin
            if (!rst_n || load)
               pre <= '0;
            else if (step)
               pre <= pre + 1'b1;
         end
         assign tick = (pre == {PRE_W{1'b1}});
      end else begin : g_nopre
         assign tick = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         halted <= 1'b0;
         expire <= 1'b0;
      end else if (load) begin
         cnt    <= load_val;
         halted <= 1'b0;
         expire <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (step) begin
            if (cnt == '0 || (cnt == 1 && tick)) begin
               cnt    <= '0;
               halted <= 1'b1;
               expire <= 1'b1;
            end else if (tick) begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   // R7
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);
   // R6
   expire_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |-> $past(active));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
   import wdt_pkg::*;
#(
   parameter int RELOAD_W = 24,
   parameter int PRE_W    = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   output logic [31:0] rd_data,
   output logic        wdt_expire
);
   logic                en_fire;
   logic                svc_fire;
   logic                run_q;
   logic                load;
   logic [RELOAD_W-1:0] reload_q;
   logic                unused_wr;

   generate
      if (RELOAD_W < 1 || RELOAD_W > RELOAD_MAX_W) begin : g_bad_w
         $error("keyed_wdt: RELOAD_W out of range");
      end
      if (RELOAD_W < RELOAD_MAX_W) begin : g_pad
         assign unused_wr = ^{wr_data[31:28], wr_data[RELOAD_MAX_W-1:RELOAD_W]};
      end else begin : g_full
         assign unused_wr = ^wr_data[31:28];
      end
   endgenerate

   wdt_keyseq u_en_key (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .field (wr_data[EN_LSB+1:EN_LSB]),
      .fire  (en_fire)
   );

   wdt_keyseq u_svc_key (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .field (wr_data[SVC_LSB+1:SVC_LSB]),
      .fire  (svc_fire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         reload_q <= '0;
      end else begin
         if (en_fire)
            run_q <= !run_q;
         if (wr_en)
            reload_q <= wr_data[RELOAD_W-1:0];
      end
   end

   assign load = (en_fire && !run_q) || (svc_fire && run_q);

   wdt_countdown #(.RELOAD_W(RELOAD_W), .PRE_W(PRE_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (run_q),
      .load     (load),
      .load_val (wr_data[RELOAD_W-1:0]),
      .expire   (wdt_expire)
   );

   always_comb begin
      rd_data                 = '0;
      rd_data[RELOAD_W-1:0]   = reload_q;
      rd_data[RUN_BIT]        = run_q;
   end

   // R2
   run_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> $stable(rd_data[RUN_BIT]));
   // R8
   reload_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data[RELOAD_W-1:0] == $past(wr_data[RELOAD_W-1:0]));
   // R8
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[30:24] == 7'd0);
endmodule

// File: tb/sim_keyed_wdt.sv
module sim_keyed_wdt;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        wdt_expire;
   int          errors = 0;
   int          checks = 0;

   always #4ns clk = ~clk;

   keyed_wdt u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .rd_data    (rd_data),
      .wdt_expire (wdt_expire)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_raw(input logic [31:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wr(input logic [1:0] ef, input logic [1:0] sf, input logic [23:0] rl);
      wr_raw({4'h0, sf, ef, rl});
   endtask

   // counts edges after the last write until a pulse; returns 0 if none within lim
   task automatic wait_expire(input int lim, output int cyc);
      cyc = 0;
      for (int i = 1; i <= lim; i++) begin
         @(negedge clk);
         if (wdt_expire) begin
            cyc = i;
            break;
         end
      end
   endtask

   task automatic count_pulses(input int n, output int p);
      p = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (wdt_expire) p++;
      end
   endtask

   task automatic finish_up;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #1500us;
      errors++;
      checks++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      finish_up();
   end

   initial begin
      int cyc;
      int p;
      logic run_before;
      logic run_exp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check("R1 rd_data", rd_data, 32'h0);
      check("R1 expire", {31'b0, wdt_expire}, 32'h0);

      // R2 / R3: every ordered pair in the enable field
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 4; b++) begin
            wr(2'd0, 2'd0, 24'd0);
            run_before = rd_data[31];
            wr(a[1:0], 2'd0, 24'd0);
            wr(b[1:0], 2'd0, 24'd0);
            run_exp = run_before ^ (a == 1 && b == 2);
            check((a == 1 && b == 2) ? "R2 toggle" : "R3 no toggle",
                  {31'b0, rd_data[31]}, {31'b0, run_exp});
         end
      end
      // one toggle happened: disable again
      wr(2'd1, 2'd0, 24'd0);
      wr(2'd2, 2'd0, 24'd0);
      check("R2 disable", {31'b0, rd_data[31]}, 32'h0);

      // R3: broken 1-0-2 sequence
      wr(2'd1, 2'd0, 24'd0);
      wr(2'd0, 2'd0, 24'd0);
      wr(2'd2, 2'd0, 24'd0);
      check("R3 broken seq", {31'b0, rd_data[31]}, 32'h0);

      // R6 / R7: timing sweep of reload values
      for (int n = 0; n < 4; n++) begin
         wr(2'd1, 2'd0, n[23:0]);
         wr(2'd2, 2'd0, n[23:0]);
         wait_expire(2000, cyc);
         check("R6 expiry edge", cyc, (n == 0) ? 1 : n * 256);
         @(negedge clk);
         check("R7 one cycle", {31'b0, wdt_expire}, 32'h0);
         count_pulses(700, p);
         check("R7 no repeat", p, 0);
         check("R7 still running", {31'b0, rd_data[31]}, 32'h1);
         wr(2'd1, 2'd0, n[23:0]);
         wr(2'd2, 2'd0, n[23:0]);
         check("R2 off again", {31'b0, rd_data[31]}, 32'h0);
      end

      // R4: service restarts full timeout
      wr(2'd1, 2'd0, 24'd2);
      wr(2'd2, 2'd0, 24'd2);
      count_pulses(300, p);
      check("R4 no early pulse", p, 0);
      wr(2'd0, 2'd1, 24'd2);
      wr(2'd0, 2'd2, 24'd2);
      wait_expire(2000, cyc);
      check("R4 restart edge", cyc, 512);
      // disable
      wr(2'd1, 2'd0, 24'd2);
      wr(2'd2, 2'd0, 24'd2);

      // R5: service while disabled
      wr(2'd0, 2'd1, 24'd1);
      wr(2'd0, 2'd2, 24'd1);
      count_pulses(700, p);
      check("R5 no pulse", p, 0);
      check("R5 stays off", {31'b0, rd_data[31]}, 32'h0);
      check("R8 reload stored", {8'h0, rd_data[23:0]}, 32'h1);

      // R8: read-only and reserved bits
      wr_raw(32'hF000_0ABC);
      check("R8 readback", rd_data, 32'h0000_0ABC);
      wr_raw(32'h8012_3456);
      check("R8 bit31 ignored", rd_data, 32'h0012_3456);

      finish_up();
   end
endmodule